// File: doc/BRIEF.md
# Burst Read Port for a Buffered Three-Axis Sample

This block sits between a serial register-access engine and a sample buffer. It presents the oldest buffered three-axis sample as six consecutive byte registers. The bytes are the low and high halves of X, then Y, then Z. A separate status register holds the buffer fill level. The serial engine supplies one read strobe per byte together with the byte address and an active-low chip-select. The block answers each strobe with a registered byte on the following cycle.

A read access runs from chip-select going active until it goes inactive. The first data-byte read of an access freezes the buffer head into a snapshot, so a burst sees one coherent sample. The buffer is popped once, when the access ends. That end is either the address stepping from the last data byte to the byte after it, or chip-select going inactive. A partial read therefore still pops, and the unread bytes of that sample are lost.

Each end of a data access opens a settle window of a configurable number of clock cycles. During that window the buffer is still moving its next entry forward. A data or status read that arrives inside the window sets a sticky too-early flag. In bypass mode, data reads return the live sample and no pop is issued.

Top module: `burst_reg_port`

## Requirements
- R1: After reset, `rd_data` is 0, `pop` is 0 and `early_err` is 0.
- R2: A read strobe counts when `rd_en` is 1 and `chip_sel_n` is 0. Its byte appears on `rd_data` in the following cycle. Addresses 0x32 to 0x37 map to sample bits [7:0], [15:8], [23:16], [31:24], [39:32] and [47:40], in that order. Any address other than the data bytes and 0x39 reads 0. `rd_data` is 0 in every cycle after a cycle with no counted strobe.
- R3: In a buffered mode (`mode` 1, 2 or 3), the first data read of an access returns the current `fifo_head` byte and captures the whole head. Later data reads in the same access return bytes of that capture, even if `fifo_head` changes.
- R4: In a buffered mode, a counted read of 0x38 that directly follows a counted read of 0x37 in the same access ends the access. `pop` is 1 for exactly one cycle, in the cycle after that strobe.
- R5: An access that has read data ends when `chip_sel_n` is 1 at a clock edge, and `pop` follows in the next cycle. This holds even if only one byte was read.
- R6: At most one pop is issued per access. Raising chip-select after a 0x37/0x38 ending issues no further pop.
- R7: With `mode` 0 (bypass), data reads return bytes of `live_sample` and no pop is issued.
- R8: A read of 0x39 returns `status`, which is `early_err` in bit 7, zeros in the bits between, and `fifo_level` in the low bits.
- R9: Consider the clock edge at which an access ends. A counted data or status read at any of the next `SETTLE_CYC` edges sets `early_err`, and `early_err` then stays 1 until reset. A read at a later edge leaves it unchanged.
- R10: An access that ends while `fifo_level` is 0 issues no pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Active-low access select |
| rd_en | input | 1 | Byte read strobe |
| rd_addr | input | AW | Byte register address |
| mode | input | 2 | Buffer mode: 0 bypass, 1 fifo, 2 stream, 3 trigger |
| fifo_head | input | 8*NBYTES | Oldest buffered sample |
| fifo_level | input | LVL_W | Buffer fill level |
| live_sample | input | 8*NBYTES | Latest live sample |
| rd_data | output | 8 | Registered read byte |
| pop | output | 1 | One-cycle buffer pop request |
| early_err | output | 1 | Sticky too-early read flag |
| status | output | 8 | Status register value |

## Verification
The bench builds the block with `SETTLE_CYC` set to 6 instead of the default of 1250. This lets the read that lands on the last cycle of the window and the read one cycle after it both be reached within a short run. The other parameters keep their defaults: a 0x32 base, three axes and a six-bit level. With these values the rollover to 0x38, the status at 0x39 and an empty buffer (level 0) are each driven directly. A behavioural model tracks every cycle, so mid-burst changes of the buffer head are checked against the frozen snapshot.

// File: rtl/burst_port_pkg.sv
package burst_port_pkg;

    typedef enum logic [1:0] {
        MODE_BYPASS  = 2'd0,
        MODE_FIFO    = 2'd1,
        MODE_STREAM  = 2'd2,
        MODE_TRIGGER = 2'd3
    } buf_mode_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/burst_addr_dec.sv
module burst_addr_dec #(
    parameter int          AW     = 8,
    parameter int          NBYTES = 6,
    parameter logic [AW-1:0] BASE = 8'h32
) (
    input  logic [AW-1:0]               addr,
    output logic                        is_data,
    output logic                        is_last,
    output logic                        is_roll,
    output logic                        is_status,
    output logic [$clog2(NBYTES)-1:0]   byte_idx
);
    localparam int IDX_W = $clog2(NBYTES);
    localparam logic [AW-1:0] LAST_A   = BASE + AW'(NBYTES - 1);
    localparam logic [AW-1:0] ROLL_A   = BASE + AW'(NBYTES);
    localparam logic [AW-1:0] STATUS_A = BASE + AW'(NBYTES + 1);

    always_comb begin
        is_data   = (addr >= BASE) && (addr <= LAST_A);
        is_last   = (addr == LAST_A);
        is_roll   = (addr == ROLL_A);
        is_status = (addr == STATUS_A);
        byte_idx  = IDX_W'(addr - BASE);
    end
endmodule

// File: rtl/burst_byte_sel.sv
module burst_byte_sel #(
    parameter int NBYTES = 6
) (
    input  logic [8*NBYTES-1:0]         sample,
    input  logic [$clog2(NBYTES)-1:0]   idx,
    output logic [7:0]                  byte_o
);
    logic [7:0] lanes [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lanes[g] = sample[8*g +: 8];
    end

    always_comb begin
        byte_o = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (int'(idx) == i) byte_o = lanes[i];
        end
    end
endmodule

// File: rtl/burst_settle_timer.sv
module burst_settle_timer #(
    parameter int SETTLE_CYC = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)               cnt_d = CNT_W'(SETTLE_CYC);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/burst_reg_port.sv
module burst_reg_port
    import burst_port_pkg::*;
#(
    parameter int            AW         = 8,
    parameter int            AXES       = 3,
    parameter int            LVL_W      = 6,
    parameter int            SETTLE_CYC = 1250,
    parameter logic [AW-1:0] DATA_BASE  = 8'h32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   chip_sel_n,
    input  logic                   rd_en,
    input  logic [AW-1:0]          rd_addr,
    input  logic [1:0]             mode,
    input  logic [16*AXES-1:0]     fifo_head,
    input  logic [LVL_W-1:0]       fifo_level,
    input  logic [16*AXES-1:0]     live_sample,
    output logic [7:0]             rd_data,
    output logic                   pop,
    output logic                   early_err,
    output logic [7:0]             status
);
    localparam int NBYTES = 2 * AXES;
    localparam int SW     = 8 * NBYTES;
    localparam int IDX_W  = $clog2(NBYTES);
    localparam int PAD_W  = 7 - LVL_W;

    typedef struct packed {
        logic          active;
        logic          last_hi;
        logic [SW-1:0] snap;
        logic [7:0]    rdata;
        logic          pop;
        logic          err;
    } port_state_t;

    port_state_t st_d, st_q;

    logic             is_data, is_last, is_roll, is_status;
    logic [IDX_W-1:0] byte_idx;
    logic [7:0]       head_byte, snap_byte, live_byte;
    logic             settle_busy;
    logic             cs_act, strobe, buffered, end_acc;

    burst_addr_dec #(.AW(AW), .NBYTES(NBYTES), .BASE(DATA_BASE)) u_dec (
        .addr      (rd_addr),
        .is_data   (is_data),
        .is_last   (is_last),
        .is_roll   (is_roll),
        .is_status (is_status),
        .byte_idx  (byte_idx)
    );

    burst_byte_sel #(.NBYTES(NBYTES)) u_sel_head (
        .sample (fifo_head), .idx (byte_idx), .byte_o (head_byte)
    );
    burst_byte_sel #(.NBYTES(NBYTES)) u_sel_snap (
        .sample (st_q.snap), .idx (byte_idx), .byte_o (snap_byte)
    );
    burst_byte_sel #(.NBYTES(NBYTES)) u_sel_live (
        .sample (live_sample), .idx (byte_idx), .byte_o (live_byte)
    );

    burst_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (end_acc),
        .busy  (settle_busy)
    );

    assign status = {st_q.err, {PAD_W{1'b0}}, fifo_level};

    always_comb begin
        cs_act   = !chip_sel_n;
        strobe   = rd_en && cs_act;
        buffered = (buf_mode_e'(mode) != MODE_BYPASS);
        end_acc  = st_q.active && ((strobe && is_roll && st_q.last_hi) || !cs_act);

        st_d       = st_q;
        st_d.rdata = '0;
        st_d.pop   = 1'b0;

        // byte returned for this strobe
        if (strobe && is_data) begin
            if (!buffered)        st_d.rdata = live_byte;
            else if (st_q.active) st_d.rdata = snap_byte;
            else                  st_d.rdata = head_byte;
        end else if (strobe && is_status) begin
            st_d.rdata = status;
        end

        // reads inside the settle window
        if (strobe && (is_data || is_status) && settle_busy) st_d.err = 1'b1;

        // access lifecycle: one pop at the end, snapshot at the start
        if (end_acc) begin
            st_d.active = 1'b0;
            st_d.pop    = (fifo_level != '0);
        end else if (strobe && is_data && buffered && !st_q.active) begin
            st_d.active = 1'b1;
            st_d.snap   = fifo_head;
        end

        if (!cs_act)     st_d.last_hi = 1'b0;
        else if (strobe) st_d.last_hi = is_last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.rdata;
    assign pop       = st_q.pop;
    assign early_err = st_q.err;
endmodule

// File: rtl/burst_reg_port_chk.sv
module burst_reg_port_chk #(
    parameter int LVL_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chip_sel_n,
    input logic             rd_en,
    input logic [LVL_W-1:0] fifo_level,
    input logic [7:0]       rd_data,
    input logic             pop,
    input logic             early_err
);
    // R6
    pop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !pop);

    // R10
    pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> ($past(fifo_level) != '0));

    // R5
    pop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> $past(chip_sel_n || rd_en));

    // R2
    idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !chip_sel_n) |=> (rd_data == 8'h00));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        early_err |=> early_err);

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(early_err) |-> $past(rd_en && !chip_sel_n));
endmodule

bind burst_reg_port burst_reg_port_chk #(.LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_sel_n (chip_sel_n),
    .rd_en      (rd_en),
    .fifo_level (fifo_level),
    .rd_data    (rd_data),
    .pop        (pop),
    .early_err  (early_err)
);

// File: tb/burst_reg_port_test.sv
module burst_reg_port_test;
    localparam int S = 6;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        chip_sel_n = 1;
    logic        rd_en = 0;
    logic [7:0]  rd_addr = 0;
    logic [1:0]  mode = 0;
    logic [47:0] fifo_head = 0;
    logic [5:0]  fifo_level = 0;
    logic [47:0] live_sample = 0;
    logic [7:0]  rd_data;
    logic        pop;
    logic        early_err;
    logic [7:0]  status;

    integer checks = 0, errors = 0, pops = 0;
    bit     done = 0;

    always #2 clk = ~clk;

    burst_reg_port #(.SETTLE_CYC(S)) uut (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .rd_en(rd_en),
        .rd_addr(rd_addr), .mode(mode), .fifo_head(fifo_head),
        .fifo_level(fifo_level), .live_sample(live_sample),
        .rd_data(rd_data), .pop(pop), .early_err(early_err), .status(status)
    );

    // behavioural reference
    bit          m_active, m_last_hi, m_pop, m_err, m_cs, m_rd, m_end, m_isdata, m_isstat;
    logic [47:0] m_snap;
    logic [7:0]  m_rdata;
    integer      m_cnt, m_off;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_last_hi = 0; m_pop = 0; m_err = 0;
            m_snap = 0; m_rdata = 0; m_cnt = 0;
        end else begin
            m_cs     = !chip_sel_n;
            m_rd     = rd_en && m_cs;
            m_isdata = (rd_addr >= 8'h32) && (rd_addr <= 8'h37);
            m_isstat = (rd_addr == 8'h39);
            m_end    = m_active && ((m_rd && rd_addr == 8'h38 && m_last_hi) || !m_cs);
            m_rdata  = 0;
            m_off    = int'(rd_addr) - 'h32;
            if (m_rd && m_isdata) begin
                if (mode == 0)     m_rdata = live_sample[8*m_off +: 8];
                else if (m_active) m_rdata = m_snap[8*m_off +: 8];
                else               m_rdata = fifo_head[8*m_off +: 8];
            end else if (m_rd && m_isstat) begin
                m_rdata = {m_err, 1'b0, fifo_level};
            end
            if (m_rd && (m_isdata || m_isstat) && m_cnt > 0) m_err = 1;
            m_pop = 0;
            if (m_end) begin
                m_active = 0;
                m_pop = (fifo_level != 0);
                m_cnt = S;
            end else begin
                if (m_cnt > 0) m_cnt = m_cnt - 1;
                if (m_rd && m_isdata && mode != 0 && !m_active) begin
                    m_active = 1;
                    m_snap = fifo_head;
                end
            end
            if (!m_cs)     m_last_hi = 0;
            else if (m_rd) m_last_hi = (rd_addr == 8'h37);
        end
    end

    task automatic check(input bit ok, input string tag, input integer act, input integer exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(rd_data == m_rdata, "R2/R3/R7 rd_data", rd_data, m_rdata);
            check(pop == m_pop, "R4/R5/R6 pop", pop, m_pop);
            check(early_err == m_err, "R9 early_err", early_err, m_err);
            check(status == {m_err, 1'b0, fifo_level}, "R8 status", status, {m_err, 1'b0, fifo_level});
            if (pop) pops++;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic rd(input logic [7:0] a);
        chip_sel_n = 0; rd_en = 1; rd_addr = a;
        tick();
        rd_en = 0;
    endtask

    task automatic cs_up();
        chip_sel_n = 1; rd_en = 0;
        tick();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic burst_full();
        for (int a = 'h32; a <= 'h38; a++) rd(8'(a));
    endtask

    integer p0;

    initial begin
        fork
            begin
                #(4 * 200000);
                if (!done) begin
                    errors++;
                    $display("FAIL watchdog expired");
                    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                    $finish;
                end
            end
        join_none

        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(rd_data == 0 && pop == 0 && early_err == 0, "R1 reset", {rd_data, pop, early_err}, 0);
        tick();

        // R7 bypass: live data, no pop
        mode = 0; live_sample = 48'hA6A5A4A3A2A1; fifo_level = 6'd9;
        p0 = pops;
        rd(8'h32);
        @(negedge clk);
        check(rd_data == 8'hA1, "R2 X low byte", rd_data, 8'hA1);
        tick();
        for (int a = 'h33; a <= 'h38; a++) rd(8'(a));
        rd(8'h3A);
        @(negedge clk);
        check(rd_data == 8'h00, "R2 unmapped reads 0", rd_data, 0);
        tick();
        cs_up(); idle(3);
        @(negedge clk);
        check(pops == p0, "R7 no pop in bypass", pops - p0, 0);
        tick(); idle(S);

        // R3/R4/R6 fifo burst with head changing mid-burst
        mode = 1; fifo_level = 6'd5; fifo_head = 48'h665544332211;
        p0 = pops;
        rd(8'h32);
        fifo_head = 48'hFFEEDDCCBBAA;
        rd(8'h33);
        @(negedge clk);
        check(rd_data == 8'h22, "R3 snapshot byte", rd_data, 8'h22);
        tick();
        for (int a = 'h34; a <= 'h37; a++) rd(8'(a));
        rd(8'h38);
        @(negedge clk);
        check(pop == 1'b1, "R4 pop after 0x38", pop, 1);
        tick();
        cs_up(); idle(2);
        @(negedge clk);
        check(pops - p0 == 1, "R6 single pop", pops - p0, 1);
        tick(); idle(S);

        // R5 single byte read then chip-select release
        p0 = pops;
        rd(8'h34);
        cs_up();
        @(negedge clk);
        check(pop == 1'b1, "R5 pop on cs release", pop, 1);
        tick();
        idle(S - 1);
        rd(8'h39);
        @(negedge clk);
        check(early_err == 1'b0, "R9 read after window", early_err, 0);
        check(rd_data == {2'b00, 6'd5}, "R8 status read", rd_data, 5);
        tick();
        cs_up();

        // R9 status read right after a burst end
        burst_full();
        rd(8'h39);
        @(negedge clk);
        check(early_err == 1'b1, "R9 early read flagged", early_err, 1);
        tick();
        cs_up(); idle(S + 4);
        @(negedge clk);
        check(early_err == 1'b1, "R9 flag sticky", early_err, 1);
        tick();
        rd(8'h39);
        @(negedge clk);
        check(rd_data == 8'h85, "R8 status shows flag", rd_data, 8'h85);
        tick();
        cs_up(); idle(S);

        // R10 empty buffer: no pop
        fifo_level = 0;
        p0 = pops;
        rd(8'h32);
        cs_up(); idle(2);
        @(negedge clk);
        check(pops == p0, "R10 no pop when empty", pops - p0, 0);
        tick(); idle(S);

        // R4 stream and trigger modes
        fifo_level = 6'd3;
        for (int m = 2; m <= 3; m++) begin
            mode = 2'(m);
            fifo_head = 48'h0102030405060 + 48'(m);
            p0 = pops;
            burst_full();
            cs_up(); idle(S + 1);
            @(negedge clk);
            check(pops - p0 == 1, "R4 pop in buffered mode", pops - p0, 1);
            tick();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule